// File: doc/BRIEF.md
# Serial Display Command Parser

This block sits behind a byte-wide serial receiver in a display controller. Each received byte arrives with a select bit. Bytes with the select bit high are pixel data: they pass straight through, one cycle later, to the framebuffer address generator. Bytes with the select bit low form commands. The first byte of a command is an opcode, and the opcode decides how many argument bytes follow.

When the last argument of a command has arrived, the parser carries out the command. It can load a column window, load a row window or set the remap register. Opcodes that the parser accepts but has no use for only absorb their argument bytes. An opcode the parser does not recognise gives a one-cycle error pulse, and the next byte is parsed as a fresh opcode. A change of the select bit in the middle of a command does not disturb that command.

Top module: `disp_cmd_parser`

## Requirements
- R1: A byte with `in_sel` high appears on `pix_byte`, with `pix_valid` high, in the cycle after it is presented. It never causes a window load, a remap change or an error pulse.
- R2: Opcode 0x15 takes two argument bytes, a first column and a last column. After the second argument, `col_load` pulses for one cycle with `col_first` = arg1 mod 64 and `col_last` = arg2 mod 64. Argument bytes are never decoded as opcodes.
- R3: Opcode 0x75 takes two argument bytes. After the second, `row_load` pulses with `row_first` = arg1 mod 80 and `row_last` = arg2 mod 80.
- R4: Opcode 0xA0 takes one argument, which is copied whole into `remap`. In `remap`, bit 2 selects vertical increment, bit 0 swaps columns, bit 1 swaps nibbles, bit 4 swaps COM and bit 6 splits COM.
- R5: Opcodes 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF each absorb exactly one argument byte and have no other effect.
- R6: Opcodes 0x84 to 0x86, 0xA4 to 0xA7, 0xAE, 0xAF and 0xE3 complete on the opcode byte itself, with no effect. The next command byte is taken as an opcode.
- R7: Opcode 0xB8 absorbs exactly eight argument bytes with no effect.
- R8: Opcode 0xFF is dropped as filler. It raises no error and takes no arguments.
- R9: Any other opcode makes `bad_cmd` high for exactly one cycle, the cycle after the opcode byte. Parsing then resumes at the next byte.
- R10: Pixel bytes that arrive between the bytes of a command are forwarded. The partial command is kept and completes with its remaining command bytes.
- R11: After reset, `col_first` = 0, `col_last` = 63, `row_first` = 0, `row_last` = 79 and `remap` = 0, and no output pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | A received byte is present this cycle |
| in_sel | input | 1 | 1 = pixel data, 0 = command byte |
| in_byte | input | 8 | Received byte |
| pix_valid | output | 1 | Forwarded pixel byte valid |
| pix_byte | output | 8 | Forwarded pixel byte |
| col_load | output | 1 | One-cycle column window load strobe |
| col_first | output | 6 | Column window start |
| col_last | output | 6 | Column window end |
| row_load | output | 1 | One-cycle row window load strobe |
| row_first | output | 7 | Row window start |
| row_last | output | 7 | Row window end |
| remap | output | 8 | Remap configuration |
| bad_cmd | output | 1 | One-cycle pulse on an unknown opcode |

## Verification
The command stream is tried with several argument patterns:
- Window arguments that lie above and below each modulus, which shows whether the reduction is done.
- Argument bytes whose values are themselves opcodes. These would produce loads or errors if argument counting slipped by even one byte.
- Sequences of zero-argument, one-argument and eight-argument opcodes, each followed by a real window command. This separates the three argument counts.

Pixel bytes placed inside a partial command, together with filler and unknown opcodes before a valid command, show that the parser state survives a mode change and recovers after an error.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;
  localparam int NARG_W = 4;

  typedef enum logic [2:0] {
    K_COL    = 3'd0,
    K_ROW    = 3'd1,
    K_REMAP  = 3'd2,
    K_SKIP   = 3'd3,
    K_FILLER = 3'd4,
    K_BAD    = 3'd5
  } op_kind_e;

  typedef struct packed {
    op_kind_e          kind;
    logic [NARG_W-1:0] nargs;
  } op_info_t;
endpackage

// File: rtl/disp_op_decode.sv
module disp_op_decode
  import disp_cmd_pkg::*;
(
  input  logic [7:0] opcode,
  output op_info_t   info
);
  always_comb begin
    info.kind  = K_BAD;
    info.nargs = '0;
    case (opcode)
      8'h15: begin info.kind = K_COL;   info.nargs = NARG_W'(2); end
      8'h75: begin info.kind = K_ROW;   info.nargs = NARG_W'(2); end
      8'hA0: begin info.kind = K_REMAP; info.nargs = NARG_W'(1); end
      8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD, 8'hB1, 8'hB2, 8'hB3,
      8'hBC, 8'hBE, 8'hBF: begin
        info.kind = K_SKIP; info.nargs = NARG_W'(1);
      end
      8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
      8'hAE, 8'hAF, 8'hE3: begin
        info.kind = K_SKIP; info.nargs = '0;
      end
      8'hB8: begin info.kind = K_SKIP;   info.nargs = NARG_W'(8); end
      8'hFF: begin info.kind = K_FILLER; info.nargs = '0; end
      default: begin info.kind = K_BAD;  info.nargs = '0; end
    endcase
  end
endmodule

// File: rtl/disp_arg_buf.sv
module disp_arg_buf #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DEPTH-1:0][DATA_W-1:0] slot_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[i] <= '0;
      else if (slot_en) slot_q[i] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/disp_cmd_seq.sv
module disp_cmd_seq
  import disp_cmd_pkg::*;
#(
  parameter int ARG_DEPTH = 8,
  parameter int COL_COUNT = 64,
  parameter int ROW_COUNT = 80,
  localparam int IDX_W = $clog2(ARG_DEPTH),
  localparam int COL_W = $clog2(COL_COUNT),
  localparam int ROW_W = $clog2(ROW_COUNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  input  op_info_t         info,
  input  logic [7:0]       prev_arg,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic             col_load,
  output logic [COL_W-1:0] col_first,
  output logic [COL_W-1:0] col_last,
  output logic             row_load,
  output logic [ROW_W-1:0] row_first,
  output logic [ROW_W-1:0] row_last,
  output logic [7:0]       remap,
  output logic             bad_cmd
);
  function automatic logic [COL_W-1:0] col_wrap(input logic [7:0] v);
    int t;
    t = int'(v) % COL_COUNT;
    return t[COL_W-1:0];
  endfunction

  function automatic logic [ROW_W-1:0] row_wrap(input logic [7:0] v);
    int t;
    t = int'(v) % ROW_COUNT;
    return t[ROW_W-1:0];
  endfunction

  logic [NARG_W-1:0] cnt_q, cnt_d;
  op_info_t          op_q, op_d;
  logic              fire_col, fire_row, fire_remap, fire_bad;
  logic [NARG_W-1:0] wr_pos, rd_pos;

  assign wr_pos = cnt_q - NARG_W'(1);
  assign rd_pos = cnt_q - NARG_W'(2);
  assign wr_idx = wr_pos[IDX_W-1:0];
  assign rd_idx = rd_pos[IDX_W-1:0];

  // next-state
  always_comb begin
    cnt_d      = cnt_q;
    op_d       = op_q;
    wr_en      = 1'b0;
    fire_col   = 1'b0;
    fire_row   = 1'b0;
    fire_remap = 1'b0;
    fire_bad   = 1'b0;
    if (cmd_valid) begin
      if (cnt_q == '0) begin
        case (info.kind)
          K_BAD:    fire_bad = 1'b1;
          K_FILLER: ;
          default: begin
            if (info.nargs != '0) begin
              op_d  = info;
              cnt_d = NARG_W'(1);
            end
          end
        endcase
      end else begin
        wr_en = 1'b1;
        if (cnt_q == op_q.nargs) begin
          cnt_d = '0;
          case (op_q.kind)
            K_COL:   fire_col   = 1'b1;
            K_ROW:   fire_row   = 1'b1;
            K_REMAP: fire_remap = 1'b1;
            default: ;
          endcase
        end else begin
          cnt_d = cnt_q + NARG_W'(1);
        end
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      op_q.kind  <= K_SKIP;
      op_q.nargs <= '0;
    end else if (cmd_valid) begin
      cnt_q <= cnt_d;
      op_q  <= op_d;
    end
  end

  // output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_load  <= 1'b0;
      row_load  <= 1'b0;
      bad_cmd   <= 1'b0;
      col_first <= '0;
      col_last  <= COL_W'(COL_COUNT - 1);
      row_first <= '0;
      row_last  <= ROW_W'(ROW_COUNT - 1);
      remap     <= '0;
    end else begin
      col_load <= fire_col;
      row_load <= fire_row;
      bad_cmd  <= fire_bad;
      if (fire_col) begin
        col_first <= col_wrap(prev_arg);
        col_last  <= col_wrap(cmd_byte);
      end
      if (fire_row) begin
        row_first <= row_wrap(prev_arg);
        row_last  <= row_wrap(cmd_byte);
      end
      if (fire_remap) remap <= cmd_byte;
    end
  end
endmodule

// File: rtl/disp_cmd_parser.sv
module disp_cmd_parser
  import disp_cmd_pkg::*;
#(
  parameter int ARG_DEPTH = 8,
  parameter int COL_COUNT = 64,
  parameter int ROW_COUNT = 80,
  localparam int IDX_W = $clog2(ARG_DEPTH),
  localparam int COL_W = $clog2(COL_COUNT),
  localparam int ROW_W = $clog2(ROW_COUNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sel,
  input  logic [7:0]       in_byte,
  output logic             pix_valid,
  output logic [7:0]       pix_byte,
  output logic             col_load,
  output logic [COL_W-1:0] col_first,
  output logic [COL_W-1:0] col_last,
  output logic             row_load,
  output logic [ROW_W-1:0] row_first,
  output logic [ROW_W-1:0] row_last,
  output logic [7:0]       remap,
  output logic             bad_cmd
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic cmd_valid, dat_valid;
  assign cmd_valid = in_valid && !in_sel;
  assign dat_valid = in_valid &&  in_sel;

  // pixel bypass
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pix_valid <= 1'b0;
    else            pix_valid <= dat_valid;
  end
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)     pix_byte <= '0;
    else if (dat_valid) pix_byte <= in_byte;
  end

  op_info_t         info;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       prev_arg;

  disp_op_decode u_dec (
    .opcode (in_byte),
    .info   (info)
  );

  disp_arg_buf #(.DEPTH(ARG_DEPTH), .DATA_W(8)) u_args (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (in_byte),
    .rd_idx  (rd_idx),
    .rd_data (prev_arg)
  );

  disp_cmd_seq #(
    .ARG_DEPTH (ARG_DEPTH),
    .COL_COUNT (COL_COUNT),
    .ROW_COUNT (ROW_COUNT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd_valid (cmd_valid),
    .cmd_byte  (in_byte),
    .info      (info),
    .prev_arg  (prev_arg),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .rd_idx    (rd_idx),
    .col_load  (col_load),
    .col_first (col_first),
    .col_last  (col_last),
    .row_load  (row_load),
    .row_first (row_first),
    .row_last  (row_last),
    .remap     (remap),
    .bad_cmd   (bad_cmd)
  );
endmodule

// File: rtl/disp_cmd_parser_chk.sv
module disp_cmd_parser_chk #(
  parameter int ROW_COUNT = 80,
  localparam int ROW_W = $clog2(ROW_COUNT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sel,
  input logic [7:0]       in_byte,
  input logic             pix_valid,
  input logic [7:0]       pix_byte,
  input logic             col_load,
  input logic             row_load,
  input logic [ROW_W-1:0] row_first,
  input logic [ROW_W-1:0] row_last,
  input logic [7:0]       remap,
  input logic             bad_cmd
);
  a_r1_pix_forward: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_sel) |-> (pix_valid && pix_byte == $past(in_byte)));

  a_r1_data_inert: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_sel) |-> (!col_load && !row_load && !bad_cmd));

  a_r2_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    !(col_load && row_load));

  a_r3_row_range: assert property (@(posedge clk) disable iff (!rst_n)
    row_load |-> (int'(row_first) < ROW_COUNT && int'(row_last) < ROW_COUNT));

  a_r4_remap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid && !in_sel) |-> $stable(remap));

  a_r9_bad_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |-> $past(in_valid && !in_sel));
endmodule

bind disp_cmd_parser disp_cmd_parser_chk #(.ROW_COUNT(ROW_COUNT)) u_chk (.*);

// File: tb/tb_disp_cmd_parser.sv
module tb_disp_cmd_parser;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, in_valid, in_sel;
  logic [7:0] in_byte;
  logic       pix_valid, col_load, row_load, bad_cmd;
  logic [7:0] pix_byte, remap;
  logic [5:0] col_first, col_last;
  logic [6:0] row_first, row_last;

  int checks = 0, failures = 0;
  int n_pix, n_col, n_row, n_bad;
  logic [7:0] last_pix;
  bit done = 0;

  disp_cmd_parser dut (.*);

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    n_pix = 0; n_col = 0; n_row = 0; n_bad = 0;
  endtask

  task automatic capture();
    if (pix_valid) begin n_pix++; last_pix = pix_byte; end
    if (col_load) n_col++;
    if (row_load) n_row++;
    if (bad_cmd)  n_bad++;
  endtask

  // present one byte at a negedge; outputs for it are sampled at the next negedge
  task automatic send(input bit sel, input logic [7:0] b);
    in_valid = 1; in_sel = sel; in_byte = b;
    @(negedge clk);
    in_valid = 0;
    capture();
  endtask

  task automatic cmd(input logic [7:0] b); send(0, b); endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); capture(); end
  endtask

  task automatic t_reset();
    check(col_first == 0 && col_last == 63, "R11 col window", col_last, 63);
    check(row_first == 0 && row_last == 79, "R11 row window", row_last, 79);
    check(remap == 0, "R11 remap", remap, 0);
    check(!pix_valid && !col_load && !row_load && !bad_cmd, "R11 pulses", bad_cmd, 0);
  endtask

  task automatic t_data();
    clr();
    send(1, 8'h3C);
    check(n_pix == 1 && last_pix == 8'h3C, "R1 pix 3C", last_pix, 8'h3C);
    send(1, 8'hA5); send(1, 8'h15); send(1, 8'h00);
    check(n_pix == 4 && last_pix == 8'h00, "R1 pix stream", n_pix, 4);
    check(n_col == 0 && n_bad == 0 && remap == 0, "R1 no cmd effect", n_col + n_bad, 0);
  endtask

  task automatic t_col();
    clr();
    cmd(8'h15); cmd(8'hC7);
    check(n_col == 0 && n_bad == 0, "R2 no early load", n_col + n_bad, 0);
    cmd(8'h7F);
    check(n_col == 1, "R2 load strobe", n_col, 1);
    check(col_first == 7 && col_last == 63, "R2 mod 64", col_first, 7);
    idle(1);
    check(n_col == 1, "R2 single pulse", n_col, 1);
    cmd(8'h15); cmd(8'h05); cmd(8'h2A);
    check(col_first == 5 && col_last == 42, "R2 in range", col_last, 42);
  endtask

  task automatic t_row();
    clr();
    cmd(8'h75); cmd(8'hA0); cmd(8'h5F);
    check(n_row == 1 && n_bad == 0, "R3 load strobe", n_row, 1);
    check(row_first == 0 && row_last == 15, "R3 mod 80", row_last, 15);
    cmd(8'h75); cmd(8'h4F); cmd(8'h50);
    check(row_first == 79 && row_last == 0, "R3 edge", row_first, 79);
  endtask

  task automatic t_remap();
    cmd(8'hA0); cmd(8'h04);
    check(remap == 8'h04, "R4 vertical bit", remap, 8'h04);
    cmd(8'hA0); cmd(8'h53);
    check(remap == 8'h53, "R4 full byte", remap, 8'h53);
  endtask

  task automatic t_skip1();
    clr();
    cmd(8'h81); cmd(8'h15);
    cmd(8'hAD); cmd(8'hFF);
    cmd(8'hBF); cmd(8'h00);
    check(n_col == 0 && n_bad == 0 && remap == 8'h53, "R5 arg absorbed", n_col + n_bad, 0);
    cmd(8'h15); cmd(8'h01); cmd(8'h02);
    check(n_col == 1 && col_first == 1 && col_last == 2, "R5 resync", col_last, 2);
  endtask

  task automatic t_skip0();
    clr();
    cmd(8'hA4); cmd(8'hE3); cmd(8'hAF); cmd(8'h86);
    cmd(8'h75); cmd(8'h03); cmd(8'h04);
    check(n_row == 1 && row_first == 3 && row_last == 4, "R6 zero-arg", row_first, 3);
    check(n_bad == 0, "R6 no error", n_bad, 0);
  endtask

  task automatic t_b8();
    clr();
    cmd(8'hB8);
    cmd(8'h15); cmd(8'h75); cmd(8'hA0); cmd(8'h00);
    cmd(8'h15); cmd(8'h11); cmd(8'h22); cmd(8'h75);
    check(n_col == 0 && n_row == 0 && n_bad == 0 && remap == 8'h53,
          "R7 eight args", n_col + n_row + n_bad, 0);
    cmd(8'h15); cmd(8'h09); cmd(8'h0A);
    check(n_col == 1 && col_first == 9 && col_last == 10, "R7 resync", col_first, 9);
  endtask

  task automatic t_filler();
    clr();
    cmd(8'hFF); cmd(8'hFF);
    cmd(8'hA0); cmd(8'h11);
    check(n_bad == 0, "R8 no error", n_bad, 0);
    check(remap == 8'h11, "R8 no args", remap, 8'h11);
  endtask

  task automatic t_bad();
    clr();
    cmd(8'h00);
    check(n_bad == 1, "R9 pulse", n_bad, 1);
    idle(1);
    check(n_bad == 1 && !bad_cmd, "R9 one cycle", n_bad, 1);
    cmd(8'h16); cmd(8'h15); cmd(8'h02); cmd(8'h03);
    check(n_bad == 2, "R9 second", n_bad, 2);
    check(n_col == 1 && col_first == 2 && col_last == 3, "R9 resume", col_first, 2);
  endtask

  task automatic t_mix();
    clr();
    cmd(8'h15); cmd(8'h04);
    send(1, 8'hAA);
    check(n_pix == 1 && last_pix == 8'hAA && n_col == 0, "R10 data passes", last_pix, 8'hAA);
    send(1, 8'h75);
    cmd(8'h08);
    check(n_col == 1 && col_first == 4 && col_last == 8, "R10 cmd kept", col_last, 8);
    check(n_row == 0 && n_pix == 2, "R10 no row", n_row, 0);
  endtask

  initial begin
    in_valid = 0; in_sel = 0; in_byte = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_data();
    t_col();
    t_row();
    t_remap();
    t_skip1();
    t_skip0();
    t_b8();
    t_filler();
    t_bad();
    t_mix();
    idle(2);
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule